// File: doc/BRIEF.md
# Bitstream-Driven Digital Gain Tap

This block feeds a one-bit sigma-delta modulator stream back into a sample path. Every time a sample from the interpolator arrives together with a modulator bit, the block either adds a programmable signed coefficient to that sample or subtracts the coefficient from it, depending on the bit. The result is saturated to 16 bits, registered, and presented with a valid strobe one clock later.

The coefficient is a two's complement Q15 value: 0x8000 is -1.0, 0xC000 is -0.5, 0x0000 is zero, 0x4000 is +0.5 and 0x7FFF is just below +1.0. Software loads it one byte at a time through a small register write port. The low byte is held in a staging register and only takes effect when the high byte is written, so the datapath never sees a half-updated value. A control register holds a tap-enable bit. When that bit is clear the sample passes through untouched.

Top module: `dgt_bitstream_tap`

## Requirements
- R1: With the default sign parameter, a fired sample whose bit is 1 yields sample + coefficient, and one whose bit is 0 yields sample - coefficient. Both operands are signed 16-bit two's complement values.
- R2: A write to register address 0 stores the coefficient's low byte (bits 7:0). A write to address 1 supplies its high byte (bits 15:8). The coefficient is read as Q15, so 0x4000 acts as +0.5 and 0xC000 as -0.5.
- R3: A write to address 0, or to any address other than 1, leaves the coefficient in use unchanged. A write to address 1 makes the coefficient in use equal to {written byte, last byte staged at address 0} in a single step.
- R4: The sum or difference is formed in 17 bits and clamped to 0x7FFF or 0x8000, so the output never wraps.
- R5: Address 2 bit 0 is the tap enable. While it is 0, a fired sample appears on the output unchanged.
- R6: With a coefficient of 0x0000 and the tap enabled, a fired sample appears on the output unchanged for either bit value.
- R7: out_valid is high in exactly the cycle after a clock edge at which smp_valid and bit_valid were both high, and low otherwise. out_smp changes only on such an edge and holds its value in between.
- R8: While rst_n is low the coefficient, its staging byte, the enable, out_valid and out_smp are all 0. The block leaves reset two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| reg_wdata | input | 8 | Register write data |
| bit_in | input | 1 | Modulator bitstream bit |
| bit_valid | input | 1 | Bitstream bit is valid |
| smp_in | input | 16 | Interpolated sample, signed |
| smp_valid | input | 1 | Sample is valid |
| out_smp | output | 16 | Tapped sample, signed, registered |
| out_valid | output | 1 | Output sample valid |

## Verification
The bench drives sums that would wrap in both directions, including subtracting -1.0 from zero and adding -1 to the most negative sample. A design without clamping would flip the sign of these results. It writes a lone low byte and then fires a sample; a design that commits each byte as it arrives would apply a mixed coefficient. It raises only one of the two valid inputs to catch an output strobe or data update that fires on half a handshake. It also resets in the middle of a run, enables the tap and fires a sample, which shows whether a stale coefficient survived the reset.

// File: rtl/dgt_pkg.sv
package dgt_pkg;
  typedef enum logic [1:0] {
    ADDR_COEF_LO = 2'd0,
    ADDR_COEF_HI = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_SPARE   = 2'd3
  } dgt_addr_e;

  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/dgt_rst_sync.sv
module dgt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dgt_coef_regs.sv
module dgt_coef_regs
  import dgt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int COEF_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [COEF_W-1:0] coef,
  output logic              tap_en
);
  logic [BYTE_W-1:0] stage_lo_q, stage_lo_d;
  logic [COEF_W-1:0] coef_q, coef_d;
  logic              en_q, en_d;
  logic              wr_lo, wr_hi, wr_ctrl;

  always_comb begin
    wr_lo   = reg_wr && (reg_addr == ADDR_COEF_LO);
    wr_hi   = reg_wr && (reg_addr == ADDR_COEF_HI);
    wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);

    stage_lo_d = stage_lo_q;
    coef_d     = coef_q;
    en_d       = en_q;
    if (wr_lo)   stage_lo_d = reg_wdata;
    if (wr_hi)   coef_d     = {reg_wdata, stage_lo_q};
    if (wr_ctrl) en_d       = reg_wdata[CTRL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      coef_q     <= '0;
      en_q       <= 1'b0;
    end else begin
      if (wr_lo)   stage_lo_q <= stage_lo_d;
      if (wr_hi)   coef_q     <= coef_d;
      if (wr_ctrl) en_q       <= en_d;
    end
  end

  assign coef   = coef_q;
  assign tap_en = en_q;
endmodule

// File: rtl/dgt_tap_datapath.sv
module dgt_tap_datapath #(
  parameter int W          = 16,
  parameter bit ADD_ON_ONE = 1'b1,
  localparam int EW = W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp_in,
  input  logic         smp_valid,
  input  logic         bit_in,
  input  logic         bit_valid,
  input  logic [W-1:0] coef,
  input  logic         tap_en,
  output logic [W-1:0] out_smp,
  output logic         out_valid
);
  localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

  logic          fire;
  logic          do_add;
  logic [EW-1:0] smp_x, coef_x, sum_x;
  logic [W-1:0]  clamped, result;
  logic [W-1:0]  out_smp_q, out_smp_d;
  logic          out_valid_q, out_valid_d;

  generate
    if (ADD_ON_ONE) begin : g_add_on_one
      assign do_add = bit_in;
    end else begin : g_add_on_zero
      assign do_add = ~bit_in;
    end
  endgenerate

  always_comb begin
    fire   = smp_valid && bit_valid;
    smp_x  = {smp_in[W-1], smp_in};
    coef_x = {coef[W-1], coef};
    sum_x  = do_add ? (smp_x + coef_x) : (smp_x - coef_x);
    if (sum_x[EW-1] != sum_x[W-1])
      clamped = sum_x[EW-1] ? NEG_LIMIT : POS_LIMIT;
    else
      clamped = sum_x[W-1:0];
    result      = tap_en ? clamped : smp_in;
    out_smp_d   = fire ? result : out_smp_q;
    out_valid_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_smp_q   <= '0;
      out_valid_q <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      if (fire) out_smp_q <= out_smp_d;
    end
  end

  assign out_smp   = out_smp_q;
  assign out_valid = out_valid_q;
endmodule

// File: rtl/dgt_bitstream_tap.sv
module dgt_bitstream_tap #(
  parameter int BYTE_W      = 8,
  parameter bit ADD_ON_ONE  = 1'b1,
  parameter int SYNC_STAGES = 2,
  localparam int W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              bit_in,
  input  logic              bit_valid,
  input  logic [W-1:0]      smp_in,
  input  logic              smp_valid,
  output logic [W-1:0]      out_smp,
  output logic              out_valid
);
  logic         rst_int_n;
  logic [W-1:0] coef;
  logic         tap_en;

  dgt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  dgt_coef_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .coef(coef), .tap_en(tap_en)
  );

  dgt_tap_datapath #(.W(W), .ADD_ON_ONE(ADD_ON_ONE)) u_dp (
    .clk(clk), .rst_n(rst_int_n), .smp_in(smp_in), .smp_valid(smp_valid),
    .bit_in(bit_in), .bit_valid(bit_valid), .coef(coef), .tap_en(tap_en),
    .out_smp(out_smp), .out_valid(out_valid)
  );
endmodule

// File: rtl/dgt_tap_checker.sv
module dgt_tap_checker #(
  parameter int W          = 16,
  parameter bit ADD_ON_ONE = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [1:0]   reg_addr,
  input logic         bit_in,
  input logic         bit_valid,
  input logic [W-1:0] smp_in,
  input logic         smp_valid,
  input logic [W-1:0] coef,
  input logic         tap_en,
  input logic [W-1:0] out_smp,
  input logic         out_valid
);
  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bit_valid) |=> out_valid);

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && bit_valid) |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && bit_valid) |=> $stable(out_smp));

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bit_valid && !tap_en) |=> (out_smp == $past(smp_in)));

  p_zero_coef_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bit_valid && coef == '0) |=> (out_smp == $past(smp_in)));

  p_atomic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr != 2'd1) |=> $stable(coef));

  // R4: positive plus positive must not wrap negative
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bit_valid && tap_en && bit_in == ADD_ON_ONE &&
     !smp_in[W-1] && !coef[W-1]) |=> !out_smp[W-1]);

  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && coef == '0 && !tap_en && out_smp == '0));
endmodule

bind dgt_bitstream_tap dgt_tap_checker #(.W(W), .ADD_ON_ONE(ADD_ON_ONE)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .bit_in(bit_in), .bit_valid(bit_valid), .smp_in(smp_in),
  .smp_valid(smp_valid), .coef(coef), .tap_en(tap_en),
  .out_smp(out_smp), .out_valid(out_valid)
);

// File: tb/dgt_bitstream_tap_test.sv
`timescale 1ns/1ps
module dgt_bitstream_tap_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic        bit_in, bit_valid, smp_valid;
  logic [15:0] smp_in;
  logic [15:0] out_smp;
  logic        out_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dgt_bitstream_tap uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .bit_in(bit_in), .bit_valid(bit_valid),
    .smp_in(smp_in), .smp_valid(smp_valid), .out_smp(out_smp),
    .out_valid(out_valid)
  );

  typedef struct packed {
    logic        en;
    logic [15:0] coef;
    logic [15:0] smp;
    logic        b;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h4000, 16'h1000, 1'b1, 16'h5000},  // R1 add
    '{1'b1, 16'h4000, 16'h1000, 1'b0, 16'hD000},  // R1 subtract
    '{1'b1, 16'h7FFF, 16'h7000, 1'b1, 16'h7FFF},  // R4 high clamp
    '{1'b1, 16'h7FFF, 16'h9000, 1'b0, 16'h8000},  // R4 low clamp
    '{1'b1, 16'h8000, 16'h0000, 1'b1, 16'h8000},  // R2 -1.0
    '{1'b1, 16'h8000, 16'h0000, 1'b0, 16'h7FFF},  // R4 minus -1.0
    '{1'b1, 16'h0000, 16'h1234, 1'b1, 16'h1234},  // R6
    '{1'b1, 16'h0000, 16'h1234, 1'b0, 16'h1234},  // R6
    '{1'b0, 16'h4000, 16'h1234, 1'b1, 16'h1234},  // R5
    '{1'b0, 16'h7FFF, 16'h8000, 1'b0, 16'h8000},  // R5
    '{1'b1, 16'hC000, 16'h0100, 1'b1, 16'hC100},  // R2 -0.5
    '{1'b1, 16'hC000, 16'h0100, 1'b0, 16'h4100},  // R2
    '{1'b1, 16'h0001, 16'h7FFF, 1'b0, 16'h7FFE},  // R1 lsb
    '{1'b1, 16'hFFFF, 16'h8000, 1'b1, 16'h8000}   // R4 low clamp
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Drive one handshake; on return the result is visible (negedge after capture)
  task automatic fire(input logic [15:0] s, input logic b);
    @(negedge clk);
    smp_in = s; bit_in = b; smp_valid = 1'b1; bit_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    bit_in = 1'b0; bit_valid = 1'b0; smp_valid = 1'b0; smp_in = '0;
    repeat (3) @(negedge clk);
    check("R8 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R8 out_smp in reset", {16'd0, out_smp}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: coefficient cleared by reset, so enabled tap leaves sample alone
    reg_write(2'd2, 8'h01);
    fire(16'h0321, 1'b1);
    check("R8 coef zero after reset", {16'd0, out_smp}, 32'h0321);

    for (int i = 0; i < NV; i++) begin
      reg_write(2'd0, VEC[i].coef[7:0]);
      reg_write(2'd1, VEC[i].coef[15:8]);
      reg_write(2'd2, {7'd0, VEC[i].en});
      fire(VEC[i].smp, VEC[i].b);
      check($sformatf("R7 valid vec%0d", i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R1/R2/R4/R5/R6 data vec%0d", i), {16'd0, out_smp}, {16'd0, VEC[i].exp});
      @(negedge clk);
      check($sformatf("R7 single strobe vec%0d", i), {31'd0, out_valid}, 32'd0);
    end

    // R3: lone low byte write does not reach the coefficient in use
    reg_write(2'd2, 8'h01);
    reg_write(2'd0, 8'h00);
    reg_write(2'd1, 8'h40);
    reg_write(2'd0, 8'hFF);
    reg_write(2'd3, 8'h55);
    fire(16'h0000, 1'b1);
    check("R3 staged low byte not applied", {16'd0, out_smp}, 32'h4000);
    reg_write(2'd1, 8'h10);
    fire(16'h0000, 1'b1);
    check("R3 commit on high byte", {16'd0, out_smp}, 32'h10FF);

    // R7: half handshakes produce nothing and hold data
    @(negedge clk);
    smp_in = 16'h2222; smp_valid = 1'b1; bit_valid = 1'b0;
    @(negedge clk);
    smp_valid = 1'b0;
    check("R7 sample only no valid", {31'd0, out_valid}, 32'd0);
    check("R7 sample only data held", {16'd0, out_smp}, 32'h10FF);
    bit_valid = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    check("R7 bit only no valid", {31'd0, out_valid}, 32'd0);
    check("R7 bit only data held", {16'd0, out_smp}, 32'h10FF);

    // R8: reset mid-run clears coefficient and enable
    do_reset();
    check("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R8 out_smp after reset", {16'd0, out_smp}, 32'd0);
    fire(16'h0100, 1'b1);
    check("R8 enable cleared", {16'd0, out_smp}, 32'h0100);
    reg_write(2'd2, 8'h01);
    fire(16'h0100, 1'b0);
    check("R8 coef cleared", {16'd0, out_smp}, 32'h0100);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule